// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them by fixed priority and signals a processor on a single interrupt output. Software reaches it through two byte-wide ports. The command port (address 0) takes initialization starts, read selection and end-of-interrupt commands. The data port (address 1) takes the initialization words and, once the controller is running, the mask. The processor answers the interrupt output with a one-cycle acknowledge pulse. In that same cycle the controller places an eight-bit vector on its vector bus and books the winning input as in service.

Three registers hold the state. The request register records pending lines. The service register records which inputs are being handled, and so allows nesting. The mask register gates requests away from the output. The controller can run in automatic end-of-interrupt mode, in which a served input is never held in the service register. If a request is withdrawn before the acknowledge arrives, the controller returns the vector of the lowest-priority input as a spurious answer.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and service registers read 0x00, the vector base is 0x00, automatic end-of-interrupt is off and the interrupt output is low.
- R2: A command-port write of 0x11 starts initialization from any state. It clears the service register and selects the request register for command-port reads. The next three data-port writes are taken in order as the vector base, the cascade word (accepted and ignored) and the mode word, and none of them alters the mask.
- R3: Outside initialization, a data-port write loads the mask and a data-port read returns it. A masked input never drives the interrupt output, and an all-ones mask keeps the output low.
- R4: An edge-mode input sets its request bit on a rising edge, and the bit clears if the line falls before acknowledge. An input whose LEVEL_MASK bit is 1 sets its request bit while its line is high, including after an acknowledge.
- R5: Input 0 has the highest priority. During an acknowledge pulse with a valid winner, the vector bus carries the vector base plus the winner's index.
- R6: The interrupt output is high only when some unmasked request has no service bit set at the same or higher priority. An acknowledge clears the winner's request bit and, unless automatic end-of-interrupt is on, sets its service bit.
- R7: A command-port write of 0x60+n (n = 0..7) clears service bit n only. Command values other than 0x11, 0x0A, 0x0B and 0x60..0x67 change nothing.
- R8: After a command-port write of 0x0A, command-port reads return the request register. After 0x0B they return the service register. The selection persists until it is changed.
- R9: When bit 1 of the mode word is 1, an acknowledge leaves the service register unchanged.
- R10: An acknowledge while the interrupt output is low returns the vector base plus 7 and leaves the service register unchanged. This holds even when input 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 1 | 0 = command port, 1 = data port |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (zero when busRd is low) |
| irqLines | input | 8 | Interrupt request lines |
| irqOut | output | 1 | Interrupt request to the processor |
| intAck | input | 1 | Single-cycle acknowledge pulse |
| vecOut | output | 8 | Vector, valid while intAck is high |

## Verification
A stale service bit shows up as a suppressed interrupt output. It is visible in the cycle after the acknowledge or end-of-interrupt that should have changed it, and a service-register read exposes it directly. A request register that misses an edge, or keeps a withdrawn one, shows up on the next acknowledge as a wrong vector, or as a spurious vector where a real one was due. A wrong initialization step count moves the vector base or corrupts the mask, and the next mask read or acknowledge reveals it.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [7:0] CMD_INIT    = 8'h11;
  localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
  localparam logic [4:0] CMD_EOI_TOP = 5'b01100;
  localparam int         AUTO_EOI_BIT = 1;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } initState_t;

  typedef struct packed {
    logic       loadMask;
    logic       clrSvc;
    logic       eoi;
    logic [2:0] eoiIdx;
    logic       take;
    logic       keepSvc;
  } dpOps_t;
endpackage

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter logic [NUM_IN-1:0] LEVEL_MASK = '0,
  localparam int IDXW = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpOps_t            ops,
  input  logic [NUM_IN-1:0] maskIn,
  input  logic [NUM_IN-1:0] lines,
  output logic [NUM_IN-1:0] irr,
  output logic [NUM_IN-1:0] isr,
  output logic [NUM_IN-1:0] imr,
  output logic [IDXW-1:0]   winIdx,
  output logic              winValid
);
  logic [NUM_IN-1:0] prevLines, rise, takeVec, irrNext, cand, upTo, isrNext;
  logic found;

  assign rise    = lines & ~prevLines;
  assign takeVec = ops.take ? (NUM_IN'(1) << winIdx) : '0;
  assign cand    = irr & ~imr;

  // Per-input request storage: edge or level variant chosen by parameter
  for (genvar i = 0; i < NUM_IN; i++) begin : g_req
    if (LEVEL_MASK[i]) begin : g_level
      assign irrNext[i] = lines[i] & ~takeVec[i];
    end else begin : g_edge
      assign irrNext[i] = lines[i] & ((irr[i] & ~takeVec[i]) | rise[i]);
    end
  end

  // Fixed priority, index 0 first
  always_comb begin
    winIdx = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (cand[i] && !found) begin
        winIdx = IDXW'(i);
        found  = 1'b1;
      end
    end
    for (int i = 0; i < NUM_IN; i++) begin
      upTo[i] = (IDXW'(i) <= winIdx);
    end
    winValid = found && ((isr & upTo) == '0);
  end

  always_comb begin
    isrNext = isr;
    if (ops.clrSvc) begin
      isrNext = '0;
    end else begin
      if (ops.eoi) isrNext[ops.eoiIdx] = 1'b0;
      if (ops.take && ops.keepSvc) isrNext[winIdx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLines <= '0;
      irr       <= '0;
      isr       <= '0;
      imr       <= '1;
    end else begin
      prevLines <= lines;
      irr       <= irrNext;
      isr       <= isrNext;
      if (ops.loadMask) imr <= maskIn;
    end
  end
endmodule

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int VEC_W  = 8,
  localparam int IDXW  = $clog2(NUM_IN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [7:0]       busWrData,
  input  logic             intAck,
  input  logic             winValid,
  input  logic [IDXW-1:0]  winIdx,
  output dpOps_t           ops,
  output logic [VEC_W-1:0] vecBase,
  output logic             aeoiOn,
  output logic             showSvc,
  output logic             runMode,
  output logic [VEC_W-1:0] vecOut
);
  initState_t state;
  logic cmdWr, dataWr, isInit;

  assign cmdWr   = busWr && !busAddr;
  assign dataWr  = busWr && busAddr;
  assign isInit  = cmdWr && (busWrData == CMD_INIT);
  assign runMode = (state == ST_RUN);

  always_comb begin
    ops          = '0;
    ops.loadMask = dataWr && runMode;
    ops.clrSvc   = isInit;
    ops.eoi      = cmdWr && runMode && (busWrData[7:3] == CMD_EOI_TOP);
    ops.eoiIdx   = busWrData[2:0];
    ops.take     = intAck && winValid;
    ops.keepSvc  = !aeoiOn;
  end

  assign vecOut = !intAck ? '0
                : vecBase + (winValid ? VEC_W'(winIdx) : VEC_W'(NUM_IN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      vecBase <= '0;
      aeoiOn  <= 1'b0;
      showSvc <= 1'b0;
    end else if (isInit) begin
      state   <= ST_BASE;
      showSvc <= 1'b0;
    end else begin
      if (dataWr) begin
        case (state)
          ST_BASE: begin
            vecBase <= VEC_W'(busWrData);
            state   <= ST_CASC;
          end
          ST_CASC: state <= ST_MODE;
          ST_MODE: begin
            aeoiOn <= busWrData[AUTO_EOI_BIT];
            state  <= ST_RUN;
          end
          default: state <= ST_RUN;
        endcase
      end
      if (cmdWr && runMode) begin
        if (busWrData == CMD_SEL_REQ) showSvc <= 1'b0;
        else if (busWrData == CMD_SEL_SVC) showSvc <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter logic [NUM_IN-1:0] LEVEL_MASK = 8'h40,
  localparam int IDXW = $clog2(NUM_IN)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic        busAddr,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic [7:0]  irqLines,
  output logic        irqOut,
  input  logic        intAck,
  output logic [7:0]  vecOut
);
  dpOps_t            ops;
  logic [NUM_IN-1:0] irr, isr, imr;
  logic [IDXW-1:0]   winIdx;
  logic              winValid, aeoiOn, showSvc, runMode;
  logic [7:0]        vecBase;

  pic_control #(.NUM_IN(NUM_IN), .VEC_W(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .intAck(intAck), .winValid(winValid),
    .winIdx(winIdx), .ops(ops), .vecBase(vecBase), .aeoiOn(aeoiOn),
    .showSvc(showSvc), .runMode(runMode), .vecOut(vecOut)
  );

  pic_datapath #(.NUM_IN(NUM_IN), .LEVEL_MASK(LEVEL_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .ops(ops), .maskIn(busWrData[NUM_IN-1:0]),
    .lines(irqLines[NUM_IN-1:0]), .irr(irr), .isr(isr), .imr(imr),
    .winIdx(winIdx), .winValid(winValid)
  );

  assign irqOut    = winValid;
  assign busRdData = !busRd  ? 8'h00
                   : busAddr ? 8'(imr)
                   : (showSvc ? 8'(isr) : 8'(irr));
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NUM_IN = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busAddr,
  input logic [7:0]        busWrData,
  input logic              intAck,
  input logic              irqOut,
  input logic [7:0]        vecOut,
  input logic [7:0]        vecBase,
  input logic              aeoiOn,
  input logic              runMode,
  input logic [NUM_IN-1:0] isr,
  input logic [NUM_IN-1:0] imr
);
  logic cmdWr;
  assign cmdWr = busWr && !busAddr;

  a_r3_full_mask_silent: assert property (@(posedge clk) disable iff (!rstN)
    (imr == '1) |-> !irqOut);

  a_r6_top_service_blocks: assert property (@(posedge clk) disable iff (!rstN)
    isr[0] |-> !irqOut);

  a_r6_ack_books_service: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && irqOut && !aeoiOn && !cmdWr) |=> (isr != '0));

  a_r7_specific_eoi: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && runMode && busWrData[7:3] == 5'b01100 && !intAck)
      |=> !isr[$past(busWrData[2:0])]);

  a_r9_auto_eoi_empty: assert property (@(posedge clk) disable iff (!rstN)
    (aeoiOn && isr == '0) |=> (isr == '0));

  a_r10_spurious_vector: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !irqOut) |-> (vecOut == vecBase + 8'(NUM_IN - 1)));

  a_r10_spurious_no_service: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !irqOut && !cmdWr) |=> $stable(isr));
endmodule

bind prio_irq_ctrl pic_checker #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWrData(busWrData), .intAck(intAck), .irqOut(irqOut),
  .vecOut(vecOut), .vecBase(vecBase), .aeoiOn(aeoiOn),
  .runMode(runMode), .isr(isr), .imr(imr)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0, busAddr = 1'b0, intAck = 1'b0;
  logic [7:0] busWrData = 8'h00, irqLines = 8'h00;
  logic [7:0] busRdData, vecOut;
  logic irqOut;
  int checks = 0, errors = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqLines(irqLines),
    .irqOut(irqOut), .intAck(intAck), .vecOut(vecOut)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [7:0] v);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr; busWrData = v;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic addr, output logic [7:0] v);
    @(negedge clk);
    busRd = 1'b1; busAddr = addr;
    #1 v = busRdData;
    busRd = 1'b0;
  endtask

  task automatic setLines(input logic [7:0] v);
    @(negedge clk);
    irqLines = v;
    @(negedge clk);
  endtask

  // driver: push expected vector, then pulse acknowledge
  task automatic ack(input string req, input logic [7:0] exp);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(req);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  // monitor: compare vector during each acknowledge cycle
  always @(negedge clk) begin
    #1;
    if (intAck) begin
      if (expQ.size() == 0) check("ACK-unexpected", vecOut, 8'hxx);
      else check(tagQ.pop_front(), vecOut, expQ.pop_front());
    end
  end

  task automatic expRd(input string req, input logic addr, input logic [7:0] exp);
    logic [7:0] v;
    rd(addr, v);
    check(req, v, exp);
  endtask

  task automatic expIrq(input string req, input logic exp);
    @(negedge clk);
    #1 check(req, {7'b0, irqOut}, {7'b0, exp});
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expIrq("R1 irq", 1'b0);
    expRd("R1 mask", 1'b1, 8'hFF);
    expRd("R1 request", 1'b0, 8'h00);
    // R2 init sequence, base 0x20
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    expRd("R2 mask untouched", 1'b1, 8'hFF);
    wr(1, 8'hFE);
    expRd("R3 mask load", 1'b1, 8'hFE);
    wr(1, 8'hFF);
    // R4 edge sets request even when masked; R3 masked stays quiet
    setLines(8'h08);
    expRd("R4 edge request", 1'b0, 8'h08);
    expIrq("R3 masked quiet", 1'b0);
    wr(1, 8'h00);
    expIrq("R3 unmasked raise", 1'b1);
    // R5 priority: inputs 3 and 5 pending, 3 wins
    setLines(8'h28);
    ack("R5 vector 3", 8'h23);
    wr(0, 8'h0B);
    expRd("R6 service after ack", 1'b0, 8'h08);
    expIrq("R6 lower blocked", 1'b0);
    wr(0, 8'h65);
    expRd("R7 eoi other bit", 1'b0, 8'h08);
    wr(0, 8'h63);
    expRd("R8 select persists", 1'b0, 8'h00);
    expIrq("R7 eoi frees", 1'b1);
    wr(0, 8'h0A);
    expRd("R8 request select", 1'b0, 8'h20);
    ack("R5 vector 5", 8'h25);
    setLines(8'h2A);
    expIrq("R6 higher nests", 1'b1);
    ack("R6 nested vector 1", 8'h21);
    wr(0, 8'h0B);
    expRd("R6 nested service", 1'b0, 8'h22);
    wr(0, 8'h0C);
    expRd("R7 ignored command", 1'b0, 8'h22);
    wr(0, 8'h61); wr(0, 8'h65);
    expRd("R7 both cleared", 1'b0, 8'h00);
    // R10 withdrawn request, input 7 masked
    setLines(8'h00);
    wr(1, 8'h80);
    setLines(8'h10);
    expIrq("R4 edge raise", 1'b1);
    setLines(8'h00);
    expIrq("R4 withdrawn", 1'b0);
    ack("R10 spurious vector", 8'h27);
    expRd("R10 no service", 1'b0, 8'h00);
    // R4 level input 6
    wr(1, 8'h00);
    setLines(8'h40);
    ack("R4 level vector", 8'h26);
    wr(0, 8'h0A);
    expRd("R4 level reasserts", 1'b0, 8'h40);
    expIrq("R6 blocked by own", 1'b0);
    wr(0, 8'h66);
    expIrq("R4 level pending again", 1'b1);
    setLines(8'h00);
    expRd("R4 level drops", 1'b0, 8'h00);
    // R2 init clears service
    setLines(8'h01);
    ack("R5 vector 0", 8'h20);
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h02); wr(1, 8'h03);
    wr(0, 8'h0B);
    expRd("R2 service cleared", 1'b0, 8'h00);
    expRd("R2 mask kept", 1'b1, 8'h00);
    // R9 automatic end-of-interrupt
    setLines(8'h04);
    ack("R2 new base", 8'h42);
    expRd("R9 no service", 1'b0, 8'h00);
    expIrq("R9 consumed", 1'b0);
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) check("ACK-leftover", 8'(expQ.size()), 8'h00);
    finishRun();
  end
endmodule